// File: doc/BRIEF.md
# Basic-Mode Three-Port Parallel I/O Group

This block is a group of three 8-bit parallel ports, named A, B and C, plus a control register. A byte-wide host bus reaches it through a 2-bit address, a write strobe and a read strobe. The host writes control words that choose, for each port, whether its lines are inputs or outputs. Port C is split into an upper nibble and a lower nibble, and each nibble takes its own direction.

Each port has an output latch. The pin output vector drives the latch value on every line that is an output. On the host side, reading a port returns the level on each of its lines: the driven latch value for output lines, and the external pin input for input lines. A control word whose top bit is clear does not set a mode. It sets or clears one bit of the port C latch. Only plain input/output operation exists. Any other mode-field content in a mode-set word has no effect.

Top module: `ppi_port_group`

## Requirements
- R1: After reset every line is an input, so pin_oe is all zero and pin_out is all zero, and all three output latches hold zero.
- R2: A write to address 3 with wdata[7]=1 is a mode-set word. A 1 in bit 4 makes port A (pin bits 7:0) an input, bit 1 does this for port B (bits 15:8), bit 3 for port C upper (bits 23:20) and bit 0 for port C lower (bits 19:16). A 0 makes the group an output. pin_oe is 1 exactly on the output lines, so 0x80 makes all 24 lines outputs.
- R3: Every mode-set write clears all three output latches to zero.
- R4: A write to address 0, 1 or 2 loads the latch of port A, B or C. pin_out carries the latch bit on output lines and 0 on input lines.
- R5: A write to address 3 with wdata[7]=0 writes wdata[0] into bit wdata[3:1] of the port C latch. The other latch bits and all directions stay unchanged.
- R6: A read with rd_en at address 0, 1 or 2 loads rdata at that clock edge. Each bit is the latch bit for an output line and the pin_in bit for an input line. rdata holds its value while rd_en is low.
- R7: A read of address 3 returns 0xFF.
- R8: The two nibbles of port C keep independent directions, and they can be opposite at the same time.
- R9: Bits 6:5 and 2 of a mode-set word have no effect on direction or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pin_in | input | 24 | External line levels, C:B:A from high to low |
| pin_out | output | 24 | Driven line values, zero on input lines |
| pin_oe | output | 24 | Output enable per line |

## Verification
Some cases are hard to reach from the ports. One is a port C state where the two nibbles point in opposite directions. Another is a latch that was built up bit by bit through single-bit commands and then read back through a mixed-direction read. Each of these needs a mode-set word followed by several later writes with no mode-set between them. The random stimulus therefore gives mode-set words a low weight, so long runs of port and bit writes build up latch state between them. Directed sequences also force both nibble splits and address every bit position of port C.

// File: rtl/ppi_port_group.sv
module ppi_port_group #(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [PW-1:0]   wdata,
  output logic [PW-1:0]   rdata,
  input  logic [3*PW-1:0] pin_in,
  output logic [3*PW-1:0] pin_out,
  output logic [3*PW-1:0] pin_oe
);
  localparam int HW = PW / 2;
  localparam int SW = $clog2(PW);

  logic [PW-1:0] lat_a, lat_b, lat_c;
  logic          in_a, in_b, in_ch, in_cl;
  logic [3*PW-1:0] lat_all, live;
  logic          ctl_wr;

  assign ctl_wr  = wr_en && addr == 2'd3;
  assign lat_all = {lat_c, lat_b, lat_a};
  assign pin_oe  = {{HW{~in_ch}}, {HW{~in_cl}}, {PW{~in_b}}, {PW{~in_a}}};
  assign pin_out = lat_all & pin_oe;
  assign live    = (lat_all & pin_oe) | (pin_in & ~pin_oe);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
      in_a  <= 1'b1;
      in_b  <= 1'b1;
      in_ch <= 1'b1;
      in_cl <= 1'b1;
    end else if (wr_en) begin
      case (addr)
        2'd0: lat_a <= wdata;
        2'd1: lat_b <= wdata;
        2'd2: lat_c <= wdata;
        default: begin
          if (wdata[PW-1]) begin
            in_a  <= wdata[4];
            in_b  <= wdata[1];
            in_ch <= wdata[3];
            in_cl <= wdata[0];
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
          end else begin
            lat_c[wdata[SW:1]] <= wdata[0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        2'd0: rdata <= live[PW-1:0];
        2'd1: rdata <= live[2*PW-1:PW];
        2'd2: rdata <= live[3*PW-1:2*PW];
        default: rdata <= '1;
      endcase
    end
  end

  AST_MODESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wdata[PW-1] |=> pin_out == '0); // R3
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 2'd3 |=> rdata == '1); // R7
  AST_PORT_WR_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr != 2'd3 |=> $stable(pin_oe)); // R4
  AST_BITCMD_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !wdata[PW-1] |=> $stable(pin_oe) && $stable(pin_out[2*PW-1:0])); // R5
  AST_IDLE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out) && $stable(pin_oe)); // R4
  AST_IDLE_HOLDS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R6
  AST_NIBBLE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pin_oe[3*PW-1:3*PW-HW]) == 0 || $countones(pin_oe[3*PW-1:3*PW-HW]) == HW) &&
    ($countones(pin_oe[2*PW+HW-1:2*PW]) == 0 || $countones(pin_oe[2*PW+HW-1:2*PW]) == HW)); // R8
endmodule

// File: tb/ppi_port_group_tb.sv
module ppi_port_group_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] pin_in = '0;
  logic [23:0] pin_out, pin_oe;

  int checks = 0, errors = 0;
  logic [23:0] m_lat = '0;
  logic [3:0]  m_in = 4'hF; // {c_hi, c_lo, b, a}

  always #5 clk = ~clk;

  ppi_port_group u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic [23:0] exp_oe();
    return {{4{~m_in[3]}}, {4{~m_in[2]}}, {8{~m_in[1]}}, {8{~m_in[0]}}};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a, input logic [23:0] pi);
    logic [23:0] lv;
    lv = (m_lat & exp_oe()) | (pi & ~exp_oe());
    case (a)
      2'd0: return lv[7:0];
      2'd1: return lv[15:8];
      2'd2: return lv[23:16];
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    chk(req, {8'h0, pin_oe}, {8'h0, exp_oe()});
    chk(req, {8'h0, pin_out}, {8'h0, m_lat & exp_oe()});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a != 2'd3) m_lat[a*8 +: 8] = d;
    else if (d[7]) begin
      m_in = {d[3], d[0], d[1], d[4]};
      m_lat = '0;
    end else m_lat[16 + d[3:1]] = d[0];
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    e = exp_rd(a, pin_in);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {24'h0, rdata}, {24'h0, e});
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_pins("R1");
    pin_in = 24'hA5_3C_96;
    rd(2'd0, "R1"); rd(2'd2, "R1");
    // R7 control read
    rd(2'd3, "R7");
    // R2 all outputs
    wr(2'd3, 8'h80); check_pins("R2");
    chk("R2", {8'h0, pin_oe}, 32'h00FF_FFFF);
    // R4 port loads
    wr(2'd0, 8'h12); wr(2'd1, 8'h34); wr(2'd2, 8'h56); check_pins("R4");
    chk("R4", {8'h0, pin_out}, 32'h0056_3412);
    rd(2'd1, "R6");
    // R3 mode-set clears latches
    wr(2'd3, 8'h80); check_pins("R3");
    chk("R3", {8'h0, pin_out}, 32'h0);
    // R8 opposite nibbles, both splits
    wr(2'd3, 8'h88); wr(2'd2, 8'hFF); check_pins("R8");
    chk("R8", {8'h0, pin_oe[23:16]}, 32'h0F);
    rd(2'd2, "R8");
    wr(2'd3, 8'h81); wr(2'd2, 8'hFF); check_pins("R8");
    chk("R8", {8'h0, pin_oe[23:16]}, 32'hF0);
    rd(2'd2, "R6");
    // R5 every bit of port C
    wr(2'd3, 8'h80);
    for (int i = 0; i < 8; i++) begin
      wr(2'd3, {4'h0, i[2:0], 1'b1}); check_pins("R5");
    end
    chk("R5", {24'h0, pin_out[23:16]}, 32'hFF);
    wr(2'd3, 8'h06); wr(2'd3, 8'h00); check_pins("R5");
    chk("R5", {24'h0, pin_out[23:16]}, 32'hF6);
    // R9 ignored mode bits
    wr(2'd3, 8'hE4); check_pins("R9");
    chk("R9", {8'h0, pin_oe}, 32'h00FF_FFFF);
    // R2 input directions
    wr(2'd3, 8'h92); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); check_pins("R2");
    rd(2'd0, "R6"); rd(2'd1, "R6");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      pin_in = $urandom;
      case (r[3:0])
        4'd0: wr(2'd3, {1'b1, r[10:4]});
        4'd1, 4'd2, 4'd3: wr(2'd3, {4'h0, r[7:4]});
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8: wr(r[5:4] == 2'd3 ? 2'd2 : r[5:4], r[15:8]);
        default: rd(r[5:4], "R6");
      endcase
      check_pins("R4");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule